// File: doc/BRIEF.md
# Word-Counted Flash Burst Reader with Data FIFO

This block moves a burst of 32-bit words from a flash-like memory into an on-chip FIFO on behalf of a host. The host sets a byte start address, then writes a control word that holds a word count and a read-mode bit. That write launches the burst. The sequencer issues one memory request per word and moves the memory address forward by four bytes each time. It shows a busy flag until every granted word is stored. The host polls that flag, then drains the words through one fixed data offset, where each read returns the next word in fetch order.

A write of zero to the control offset ends the transaction and returns the engine to idle. The host needs this write before it can launch the next block. The control word also reports how many FIFO slots are empty, so the host knows how many words it may push through the same data offset when the engine is not fetching.

A tail shorter than four bytes is requested as a full word, and the host drops the unused bytes. A pop from an empty FIFO returns zero and raises a sticky underflow flag.

Top module: `fburst_rd`

## Requirements
- R1: After reset, no memory request is raised and the control word reads with bit 1 (busy), bit 2 (underflow) and bit 0 (active) all zero, and with the free-space field (bits 30:24) equal to DEPTH (64).
- R2: Host offsets are word indices: 0 is control, 1 is the byte start address, and 2 is FIFO data. A control write in idle with bit 0 set and a non-zero granted count sets busy (bit 1) and active (bit 0) on the next cycle. It also raises a memory request at the programmed start address.
- R3: A memory request holds its address stable until it is acknowledged, and each acknowledged word moves the next request address forward by 4.
- R4: Busy stays set until every granted word has been stored in the FIFO and then clears. Active stays set until the zero-write.
- R5: The granted count is the smaller of the requested count (control bits 15:8) and the free FIFO space at launch. It reads back in bits 15:8. A grant of zero launches no request and never sets busy.
- R6: Each read of offset 2 pops one word, and the words come out in the order they were stored.
- R7: The free-space field (bits 30:24) always equals DEPTH minus the number of stored words.
- R8: A read of offset 2 while the FIFO is empty returns zero and sets the sticky underflow bit 2.
- R9: A write of zero to control returns the engine to idle from any state. It drops any open request, clears underflow and the granted count, and keeps the words already stored.
- R10: A write to offset 2 pushes the data word when the engine is not busy and the FIFO is not full. It is ignored while busy or when the FIFO is full.
- R11: A non-zero control write while the engine is active is ignored: no new burst starts and the granted count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe (pops on the data offset) |
| host_addr_i | input | 2 | Host register word offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, valid in the cycle of the read strobe |
| mem_req_o | output | 1 | Memory word request, held until acknowledged |
| mem_addr_o | output | AW | Memory byte address of the requested word |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle, data valid with it |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
On every cycle, the assertions check that an open memory request keeps its address until acknowledged and that each acknowledged word steps the next address by four. They also check that the free count never exceeds the depth, that a zero-write idles the engine and clears underflow at once, that an empty pop raises underflow, and that a host push in idle takes exactly one slot. Only the bench scenarios can show the fetched data order against the memory contents, the clamping of the grant to the free space left by pushed words, the refusal of relaunch while active, and the prefix of words kept after a burst is aborted. The bench covers these with directed cases and with random start addresses and byte lengths whose tails round up to a whole word.

// File: rtl/fburst_pkg.sv
package fburst_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_BASE = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int CTRL_ACTIVE_BIT = 0;
    localparam int CTRL_BUSY_BIT   = 1;
    localparam int CTRL_UFLOW_BIT  = 2;
    localparam int CTRL_CNT_LSB    = 8;
    localparam int CTRL_FREE_LSB   = 24;

endpackage

// File: rtl/fburst_fifo.sv
module fburst_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic             pop_i,
    output logic [DW-1:0]    head_o,
    output logic [LVL_W-1:0] free_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        empty_o = (st_q.lvl == '0);
        full_o  = (st_q.lvl == FULL_LVL);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.wr = bump(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end
        if (do_push && !do_pop) begin
            st_d.lvl = st_q.lvl + LVL_W'(1);
        end else if (do_pop && !do_push) begin
            st_d.lvl = st_q.lvl - LVL_W'(1);
        end
        head_o = mem_q[st_q.rd];
        free_o = FULL_LVL - st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr] <= push_data_i;
        end
    end

endmodule

// File: rtl/fburst_seq.sv
module fburst_seq
    import fburst_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 8,
    parameter int LVL_W = 7,
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             abort_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [AW-1:0]    start_i,
    input  logic [LVL_W-1:0] free_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [AW-1:0]    addr_o,
    output logic             push_o,
    output logic             busy_o,
    output logic             active_o,
    output logic [CNT_W-1:0] grant_o
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] grant;
        logic [AW-1:0]    ptr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [CMP_W-1:0] free_c, cnt_c;
    logic [CNT_W-1:0] clamp;

    always_comb begin
        st_d   = st_q;
        free_c = CMP_W'(free_i);
        cnt_c  = CMP_W'(cnt_i);
        clamp  = CNT_W'((free_c < cnt_c) ? free_c : cnt_c);
        push_o = 1'b0;

        if (abort_i) begin
            st_d.st    = SEQ_IDLE;
            st_d.left  = '0;
            st_d.grant = '0;
        end else begin
            unique case (st_q.st)
                SEQ_IDLE: begin
                    if (launch_i) begin
                        st_d.grant = clamp;
                        st_d.left  = clamp;
                        st_d.ptr   = start_i;
                        st_d.st    = (clamp == '0) ? SEQ_DONE : SEQ_FETCH;
                    end
                end
                SEQ_FETCH: begin
                    if (ack_i) begin
                        push_o    = 1'b1;
                        st_d.ptr  = st_q.ptr + AW'(4);
                        st_d.left = st_q.left - CNT_W'(1);
                        if (st_q.left == CNT_W'(1)) begin
                            st_d.st = SEQ_DONE;
                        end
                    end
                end
                SEQ_DONE: begin
                    st_d = st_q;
                end
                default: begin
                    st_d.st = SEQ_IDLE;
                end
            endcase
        end

        req_o    = (st_q.st == SEQ_FETCH);
        addr_o   = st_q.ptr;
        busy_o   = (st_q.st == SEQ_FETCH);
        active_o = (st_q.st != SEQ_IDLE);
        grant_o  = st_q.grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: SEQ_IDLE, left: '0, grant: '0, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fburst_rd.sv
module fburst_rd
    import fburst_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 64,
    parameter int CNT_W = 8,
    localparam int DW    = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_i,
    input  logic          host_rd_i,
    input  logic [1:0]    host_addr_i,
    input  logic [31:0]   host_wdata_i,
    output logic [31:0]   host_rdata_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic          uflow;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             wr_ctrl, wr_base, wr_data, rd_data;
    logic             abort_w, launch_w;
    logic             busy_w, active_w, eng_push, fifo_push, empty_w, full_w;
    logic [DW-1:0]    fifo_in, head_w;
    logic [LVL_W-1:0] free_w;
    logic [CNT_W-1:0] grant_w;
    logic             uflow_w;
    logic [31:0]      ctrl_word;
    logic             unused_wdata;

    assign unused_wdata = ^{host_wdata_i[31:CTRL_CNT_LSB + CNT_W], host_wdata_i[CTRL_CNT_LSB-1:1], full_w};

    always_comb begin
        wr_ctrl  = host_wr_i && (host_addr_i == REG_CTRL);
        wr_base  = host_wr_i && (host_addr_i == REG_BASE);
        wr_data  = host_wr_i && (host_addr_i == REG_DATA);
        rd_data  = host_rd_i && (host_addr_i == REG_DATA);
        abort_w  = wr_ctrl && (host_wdata_i == '0);
        launch_w = wr_ctrl && host_wdata_i[0];
    end

    fburst_seq #(
        .AW    (AW),
        .CNT_W (CNT_W),
        .LVL_W (LVL_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch_w),
        .abort_i  (abort_w),
        .cnt_i    (host_wdata_i[CTRL_CNT_LSB +: CNT_W]),
        .start_i  (st_q.base),
        .free_i   (free_w),
        .ack_i    (mem_ack_i),
        .req_o    (mem_req_o),
        .addr_o   (mem_addr_o),
        .push_o   (eng_push),
        .busy_o   (busy_w),
        .active_o (active_w),
        .grant_o  (grant_w)
    );

    always_comb begin
        fifo_push = eng_push || (wr_data && !busy_w);
        fifo_in   = eng_push ? mem_rdata_i : host_wdata_i;
    end

    fburst_fifo #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (fifo_push),
        .push_data_i (fifo_in),
        .pop_i       (rd_data),
        .head_o      (head_w),
        .free_o      (free_w),
        .empty_o     (empty_w),
        .full_o      (full_w)
    );

    always_comb begin
        st_d = st_q;
        if (wr_base) begin
            st_d.base = host_wdata_i[AW-1:0];
        end
        if (abort_w) begin
            st_d.uflow = 1'b0;
        end else if (rd_data && empty_w) begin
            st_d.uflow = 1'b1;
        end
        uflow_w = st_q.uflow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_word                            = '0;
        ctrl_word[CTRL_ACTIVE_BIT]           = active_w;
        ctrl_word[CTRL_BUSY_BIT]             = busy_w;
        ctrl_word[CTRL_UFLOW_BIT]            = st_q.uflow;
        ctrl_word[CTRL_CNT_LSB +: CNT_W]     = grant_w;
        ctrl_word[CTRL_FREE_LSB +: LVL_W]    = free_w;
        unique case (host_addr_i)
            REG_CTRL: host_rdata_o = ctrl_word;
            REG_BASE: host_rdata_o = 32'(st_q.base);
            REG_DATA: host_rdata_o = empty_w ? '0 : head_w;
            default:  host_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/fburst_rd_chk.sv
module fburst_rd_chk #(
    parameter int AW    = 32,
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr_i,
    input logic             host_rd_i,
    input logic [1:0]       host_addr_i,
    input logic [31:0]      host_wdata_i,
    input logic             mem_req_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic             mem_ack_i,
    input logic             busy_w,
    input logic [LVL_W-1:0] free_w,
    input logic             uflow_w
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic zero_wr, data_rd, data_wr;
    assign zero_wr = host_wr_i && (host_addr_i == 2'd0) && (host_wdata_i == '0);
    assign data_rd = host_rd_i && (host_addr_i == 2'd2);
    assign data_wr = host_wr_i && (host_addr_i == 2'd2);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !zero_wr) |=> (mem_req_o && $stable(mem_addr_o)));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && !zero_wr) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(4))));

    p_free_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        free_w <= FULL_LVL);

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> (!mem_req_o && !busy_w && !uflow_w));

    p_uflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !host_wr_i && free_w == FULL_LVL) |=> uflow_w);

    p_host_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !host_rd_i && !busy_w && free_w != '0) |=> (free_w == $past(free_w) - LVL_W'(1)));

endmodule

bind fburst_rd fburst_rd_chk #(
    .AW    (AW),
    .DEPTH (DEPTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .busy_w       (busy_w),
    .free_w       (free_w),
    .uflow_w      (uflow_w)
);

// File: tb/fburst_rd_tb_top.sv
`timescale 1ns/1ps
module fburst_rd_tb_top;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    int unsigned lat_q = 0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fburst_rd #(.AW(32), .DEPTH(DEPTH), .CNT_W(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr),
        .host_rd_i    (host_rd),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .host_rdata_o (host_rdata),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_ack_i    (mem_ack),
        .mem_rdata_i  (mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic int unsigned exp_grant(input int unsigned cnt, input int unsigned free);
        return (cnt < free) ? cnt : free;
    endfunction

    // memory model: random latency 0..2 cycles, one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_q   <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_q == 0) begin
                mem_ack   <= 1'b1;
                mem_rdata <= pat(mem_addr);
                lat_q     <= $urandom % 3;
            end else begin
                lat_q <= lat_q - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        #1 host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(posedge clk);
        #1 host_rd = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] c;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd0, c);
            if (!c[1]) break;
        end
    endtask

    task automatic drain(input logic [31:0] base, input int n, input string tag);
        logic [31:0] d;
        for (int i = 0; i < n; i++) begin
            rd(2'd2, d);
            chk(d == pat(base + 32'(4 * i)), tag, d, pat(base + 32'(4 * i)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] c, d;
        int unsigned k;
        void'($urandom(32'd7013));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 0);
        rd(2'd0, c);
        chk(c[2:0] == 3'b000, "R1 status bits clear", 32'(c[2:0]), 0);
        chk(c[30:24] == 7'(DEPTH), "R1 free equals depth", 32'(c[30:24]), DEPTH);

        // R2 R3 R4 R6 R7 directed burst of five words
        wr(2'd1, 32'h0000_0100);
        wr(2'd0, 32'h0000_0501);
        chk(mem_req && mem_addr == 32'h100, "R2 request at start address", mem_addr, 32'h100);
        rd(2'd0, c);
        chk(c[1:0] == 2'b11, "R2 busy and active after launch", 32'(c[1:0]), 3);
        wait_done();
        rd(2'd0, c);
        chk(c[1:0] == 2'b01, "R4 busy clear, active held", 32'(c[1:0]), 1);
        chk(c[30:24] == 7'(DEPTH - 5), "R7 free after burst", 32'(c[30:24]), DEPTH - 5);
        drain(32'h100, 5, "R6 R3 burst data order");
        rd(2'd0, c);
        chk(c[30:24] == 7'(DEPTH), "R7 free after drain", 32'(c[30:24]), DEPTH);

        // R8 empty pop, R9 zero-write clears
        rd(2'd2, d);
        chk(d == 0, "R8 empty pop returns zero", d, 0);
        rd(2'd0, c);
        chk(c[2] == 1'b1, "R8 underflow sticky", 32'(c[2]), 1);
        wr(2'd0, 32'h0);
        rd(2'd0, c);
        chk(c[2:0] == 3'b000, "R9 zero-write idles and clears", 32'(c[2:0]), 0);

        // R5 clamp to depth, R10 push while busy ignored, R11 relaunch ignored
        wr(2'd1, 32'h0000_2000);
        wr(2'd0, 32'h0000_C801);
        wr(2'd2, 32'hDEAD_BEEF);
        wait_done();
        rd(2'd0, c);
        chk(c[15:8] == 8'(DEPTH), "R5 grant clamped to depth", 32'(c[15:8]), DEPTH);
        chk(c[30:24] == 0, "R5 fifo full after clamp", 32'(c[30:24]), 0);
        wr(2'd0, 32'h0000_0301);
        chk(mem_req == 1'b0, "R11 no relaunch while active", 32'(mem_req), 0);
        rd(2'd0, c);
        chk(c[15:8] == 8'(DEPTH), "R11 grant unchanged", 32'(c[15:8]), DEPTH);
        drain(32'h2000, DEPTH, "R10 R6 busy push ignored, clamped data");
        wr(2'd0, 32'h0);

        // R5 zero count
        wr(2'd0, 32'h0000_0001);
        chk(mem_req == 1'b0, "R5 zero grant raises no request", 32'(mem_req), 0);
        rd(2'd0, c);
        chk(c[1] == 1'b0, "R5 zero grant never busy", 32'(c[1]), 0);
        wr(2'd0, 32'h0);

        // R10 host pushes, R5 clamp to free space
        for (int i = 0; i < 10; i++) wr(2'd2, 32'h0000_1000 + 32'(i));
        rd(2'd0, c);
        chk(c[30:24] == 7'(DEPTH - 10), "R10 pushes take slots", 32'(c[30:24]), DEPTH - 10);
        wr(2'd1, 32'h0000_0400);
        wr(2'd0, 32'h0000_3C01);
        wait_done();
        rd(2'd0, c);
        chk(c[15:8] == 8'(DEPTH - 10), "R5 grant clamped to free space", 32'(c[15:8]), DEPTH - 10);
        for (int i = 0; i < 10; i++) begin
            rd(2'd2, d);
            chk(d == 32'h0000_1000 + 32'(i), "R6 pushed words first", d, 32'h0000_1000 + 32'(i));
        end
        drain(32'h400, DEPTH - 10, "R6 fetched words after pushed");
        wr(2'd0, 32'h0);

        // R10 push when full ignored
        for (int i = 0; i < DEPTH; i++) wr(2'd2, 32'h0000_5000 + 32'(i));
        wr(2'd2, 32'h0000_0BAD);
        rd(2'd0, c);
        chk(c[30:24] == 0, "R10 full stays full", 32'(c[30:24]), 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'd2, d);
            chk(d == 32'h0000_5000 + 32'(i), "R10 overflow push dropped", d, 32'h0000_5000 + 32'(i));
        end

        // R9 abort mid-burst keeps prefix
        wr(2'd1, 32'h0000_8000);
        wr(2'd0, 32'h0000_2801);
        repeat (6) @(posedge clk);
        wr(2'd0, 32'h0);
        chk(mem_req == 1'b0, "R9 abort drops request", 32'(mem_req), 0);
        rd(2'd0, c);
        chk(c[15:0] == 16'h0000, "R9 idle with grant cleared", 32'(c[15:0]), 0);
        k = DEPTH - int'(c[30:24]);
        chk(k > 0 && k < 40, "R9 partial prefix kept", k, 1);
        repeat (8) @(posedge clk);
        rd(2'd0, c);
        chk(DEPTH - int'(c[30:24]) == k, "R9 no pushes after abort", DEPTH - int'(c[30:24]), k);
        drain(32'h8000, int'(k), "R9 kept prefix data");

        // random bursts with byte lengths rounded up to whole words
        for (int it = 0; it < 20; it++) begin
            logic [31:0] base;
            int unsigned bytes, cnt, g;
            base  = $urandom & 32'h000F_FFFC;
            bytes = 1 + ($urandom % 300);
            cnt   = (bytes + 3) / 4;
            g     = exp_grant(cnt, DEPTH);
            wr(2'd1, base);
            wr(2'd0, {16'h0, 8'(cnt), 8'h01});
            wait_done();
            rd(2'd0, c);
            chk(c[15:8] == 8'(g), "R5 random grant", 32'(c[15:8]), g);
            chk(c[30:24] == 7'(DEPTH - g), "R7 random free", 32'(c[30:24]), DEPTH - g);
            drain(base, int'(g), "R3 R6 random data");
            wr(2'd0, 32'h0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule